// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block collects a parameterised number of interrupt request lines (eight by default; the parameter allows up to 256). Each line has its own conditioning stage, chosen per line as level, pulse or asynchronous. Each line also carries a programmable priority class. The controller keeps the processor's current state level, which is the class of the handler now running, or zero in the base program. Only interrupts whose class is strictly above that level are forwarded to the core. Among those, the highest class wins, and on equal classes the lowest line number wins.

The request to the core is registered and held, together with the vector number and class of the winning line, until the core acknowledges it. On acknowledge, the controller saves the current level on an internal stack and loads the winner's class as the new level. A restore strobe on handler return brings the saved level back. Handlers can therefore nest: a higher-class interrupt preempts a running handler, and lower or equal classes wait. A small write/read register port sets each line's enable, mode and class, and holds a global enable.

Top module: `nestIrqCtrl`

## Requirements
- R1: After reset, `intReq` is 0 and `curLevel` is 0. Every line configuration reads as 0 (disabled, level mode, class 0) and the global enable reads as 0.
- R2: When the top bit of `cfgAddr` is 0, the lower bits select a line. Its configuration word holds the enable in bit 5, the mode in bits 4:3 (0 level, 1 pulse, 2 or 3 asynchronous) and the class in bits 2:0. When the top bit is 1, bit 0 of the word is the global enable and all other bits read back as 0. `cfgRdata` shows the addressed word in the same cycle.
- R3: A level-mode line counts as requesting only while its input is high, with a latency of two clock edges from the input to `intReq`. It keeps no memory after the input falls.
- R4: In pulse mode, a rising edge on a line (even one cycle long) sets a sticky pending bit, and `intReq` follows three edges after the input rises. The pending bit stays set after the input falls and is cleared only by the acknowledge of that line.
- R5: An asynchronous-mode line passes through a two-flop synchronizer before edge detection, so `intReq` follows four edges after the input rises. Its pending bit is sticky and is cleared by acknowledge, as in pulse mode.
- R6: A rising edge that arrives while the line or the global enable is off is not recorded. Turning a line off discards its pending bit.
- R7: A requesting line is eligible only if its class is strictly greater than `curLevel`. Lines at or below the level wait, and they are forwarded once the level drops below their class.
- R8: Among eligible lines, the highest class wins, and ties go to the lowest line number.
- R9: Once raised, `intReq`, `intVector` and `intClass` stay unchanged until `intAck`, even if a higher-class line arrives in the meantime. `intAck` while no request is present has no effect.
- R10: On acknowledge, `curLevel` takes the winner's class and the previous level is pushed. `intReq` is low in the following cycle, and a newly eligible line can be raised one cycle after that.
- R11: `levelRestore` pops the most recently saved level. It is ignored when no level is saved, and it is ignored in the same cycle as an accepted acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqIn | input | NUM_LINES | Raw interrupt request lines |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | $clog2(NUM_LINES)+1 | Line select, or global control when the top bit is set |
| cfgWdata | input | CLASS_W+3 | Configuration write word |
| cfgRdata | output | CLASS_W+3 | Addressed configuration word |
| intReq | output | 1 | Held interrupt request to the core |
| intVector | output | $clog2(NUM_LINES) | Line number of the held request |
| intClass | output | CLASS_W | Class of the held request |
| intAck | input | 1 | Core takes the held request |
| levelRestore | input | 1 | Handler return: pop the saved level |
| curLevel | output | CLASS_W | Current processor state level |

## Verification
A corrupted level or stack pointer shows up at the ports on the next acknowledge or restore. Either `curLevel` takes the wrong value at once, or an interrupt that should be blocked is raised two cycles later, or one that should pass never comes. A stale or lost pending bit becomes visible once the level drops: the bench restores the level and watches `intReq` within three cycles. Errors in conditioning latency are caught by sampling `intReq` exactly one cycle before and at the edge where each mode must respond.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam logic [1:0] MODE_LEVEL = 2'd0;
  localparam logic [1:0] MODE_PULSE = 2'd1;

  typedef struct packed {
    logic latchWin;   // capture arbitration winner into the request holder
    logic takeAck;    // core accepted: clear pending, push level
    logic popLevel;   // handler return: pop saved level
  } ctrlStrobe_t;
endpackage

// File: rtl/irqLine.sv
module irqLine
  import irq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       irqIn,
  input  logic       lineEn,
  input  logic [1:0] mode,
  input  logic       clrPend,
  output logic       lineReq
);
  logic s1Q, s2Q, s3Q, pendQ;
  logic isAsync, isLevel, riseSeen;

  assign isAsync  = mode[1];
  assign isLevel  = (mode == MODE_LEVEL);
  assign riseSeen = isAsync ? (s2Q & ~s3Q) : (s1Q & ~s2Q);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Q <= 1'b0;
      s2Q <= 1'b0;
      s3Q <= 1'b0;
    end else begin
      s1Q <= irqIn;
      s2Q <= s1Q;
      s3Q <= s2Q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                      pendQ <= 1'b0;
    else if (!lineEn || isLevel)    pendQ <= 1'b0;
    else if (riseSeen)              pendQ <= 1'b1;
    else if (clrPend)               pendQ <= 1'b0;
  end

  assign lineReq = isLevel ? (s1Q & lineEn) : pendQ;

  // R6: a line held off for two cycles never requests
  a_r6_gated_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!lineEn && !$past(lineEn)) |-> !lineReq);
endmodule

// File: rtl/irqControl.sv
module irqControl
  import irq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        winValid,
  input  logic        intAck,
  input  logic        levelRestore,
  output ctrlStrobe_t strobe,
  output logic        intReq
);
  typedef enum logic {ST_IDLE, ST_REQ} state_t;
  state_t stateQ, stateD;

  always_comb begin
    stateD          = stateQ;
    strobe.latchWin = 1'b0;
    strobe.takeAck  = 1'b0;
    unique case (stateQ)
      ST_IDLE: if (winValid) begin
        strobe.latchWin = 1'b1;
        stateD          = ST_REQ;
      end
      ST_REQ: if (intAck) begin
        strobe.takeAck = 1'b1;
        stateD         = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
    strobe.popLevel = levelRestore && !strobe.takeAck;
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign intReq = (stateQ == ST_REQ);
endmodule

// File: rtl/irqDatapath.sv
module irqDatapath
  import irq_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int CLASS_W   = 3,
  localparam int IDXW  = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int AW    = IDXW + 1,
  localparam int DW    = CLASS_W + 3,
  localparam int DEPTH = (1 << CLASS_W) - 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqIn,
  input  logic                 cfgWe,
  input  logic [AW-1:0]        cfgAddr,
  input  logic [DW-1:0]        cfgWdata,
  output logic [DW-1:0]        cfgRdata,
  input  ctrlStrobe_t          strobe,
  output logic                 winValid,
  output logic [IDXW-1:0]      intVector,
  output logic [CLASS_W-1:0]   intClass,
  output logic [CLASS_W-1:0]   curLevel
);
  logic [CLASS_W-1:0] lineClass [NUM_LINES];
  logic [1:0]         lineMode  [NUM_LINES];
  logic [NUM_LINES-1:0] lineEnQ, lineReq;
  logic gEnQ;

  logic [IDXW-1:0]    vecQ, bestIdx;
  logic [CLASS_W-1:0] clsQ, bestCls, levelQ;
  logic [CLASS_W-1:0] stackQ [DEPTH];
  logic [CLASS_W-1:0] spQ;
  logic               bestValid;
  int                 selIdx;

  // configuration registers
  assign selIdx = int'(cfgAddr[IDXW-1:0]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gEnQ    <= 1'b0;
      lineEnQ <= '0;
      for (int i = 0; i < NUM_LINES; i++) begin
        lineClass[i] <= '0;
        lineMode[i]  <= '0;
      end
    end else if (cfgWe) begin
      if (cfgAddr[AW-1]) begin
        gEnQ <= cfgWdata[0];
      end else if (selIdx < NUM_LINES) begin
        lineEnQ[selIdx]   <= cfgWdata[DW-1];
        lineMode[selIdx]  <= cfgWdata[DW-2:DW-3];
        lineClass[selIdx] <= cfgWdata[CLASS_W-1:0];
      end
    end
  end

  always_comb begin
    cfgRdata = '0;
    if (cfgAddr[AW-1])            cfgRdata[0] = gEnQ;
    else if (selIdx < NUM_LINES)  cfgRdata = {lineEnQ[selIdx], lineMode[selIdx], lineClass[selIdx]};
  end

  // per-line conditioning
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    irqLine u_line (
      .clk     (clk),
      .rstN    (rstN),
      .irqIn   (irqIn[g]),
      .lineEn  (lineEnQ[g] & gEnQ),
      .mode    (lineMode[g]),
      .clrPend (strobe.takeAck && (vecQ == IDXW'(g))),
      .lineReq (lineReq[g])
    );
  end

  // arbitration: highest class above level, lowest index on tie
  always_comb begin
    bestValid = 1'b0;
    bestIdx   = '0;
    bestCls   = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (lineReq[i] && (lineClass[i] > levelQ) &&
          (!bestValid || lineClass[i] >= bestCls)) begin
        bestValid = 1'b1;
        bestIdx   = IDXW'(i);
        bestCls   = lineClass[i];
      end
    end
  end

  // held request data
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecQ <= '0;
      clsQ <= '0;
    end else if (strobe.latchWin) begin
      vecQ <= bestIdx;
      clsQ <= bestCls;
    end
  end

  // state level and saved-level stack
  always_ff @(posedge clk) begin
    if (!rstN) begin
      levelQ <= '0;
      spQ    <= '0;
      for (int i = 0; i < DEPTH; i++) stackQ[i] <= '0;
    end else if (strobe.takeAck) begin
      stackQ[spQ] <= levelQ;
      spQ         <= spQ + 1'b1;
      levelQ      <= clsQ;
    end else if (strobe.popLevel && spQ != '0) begin
      levelQ <= stackQ[spQ - 1'b1];
      spQ    <= spQ - 1'b1;
    end
  end

  assign winValid  = bestValid;
  assign intVector = vecQ;
  assign intClass  = clsQ;
  assign curLevel  = levelQ;

  // R10: every accepted handler finds room on the level stack
  a_r10_stack_room: assert property (@(posedge clk) disable iff (!rstN)
    strobe.takeAck |-> (spQ < CLASS_W'(DEPTH)));
  // R11: popping an empty stack leaves the level alone
  a_r11_empty_pop: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.popLevel && spQ == '0) |=> $stable(levelQ));
endmodule

// File: rtl/nestIrqCtrl.sv
module nestIrqCtrl
  import irq_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int CLASS_W   = 3,
  localparam int IDXW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int AW   = IDXW + 1,
  localparam int DW   = CLASS_W + 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqIn,
  input  logic                 cfgWe,
  input  logic [AW-1:0]        cfgAddr,
  input  logic [DW-1:0]        cfgWdata,
  output logic [DW-1:0]        cfgRdata,
  output logic                 intReq,
  output logic [IDXW-1:0]      intVector,
  output logic [CLASS_W-1:0]   intClass,
  input  logic                 intAck,
  input  logic                 levelRestore,
  output logic [CLASS_W-1:0]   curLevel
);
  ctrlStrobe_t strobe;
  logic        winValid;

  irqControl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .winValid     (winValid),
    .intAck       (intAck),
    .levelRestore (levelRestore),
    .strobe       (strobe),
    .intReq       (intReq)
  );

  irqDatapath #(.NUM_LINES(NUM_LINES), .CLASS_W(CLASS_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .irqIn     (irqIn),
    .cfgWe     (cfgWe),
    .cfgAddr   (cfgAddr),
    .cfgWdata  (cfgWdata),
    .cfgRdata  (cfgRdata),
    .strobe    (strobe),
    .winValid  (winValid),
    .intVector (intVector),
    .intClass  (intClass),
    .curLevel  (curLevel)
  );

  // R9: request and its data are held until acknowledged
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    (intReq && !intAck) |=> (intReq && $stable(intVector) && $stable(intClass)));
  // R7: a forwarded request always outranks the running level
  a_r7_above_level: assert property (@(posedge clk) disable iff (!rstN)
    intReq |-> (intClass > curLevel));
  // R10: acknowledge loads the class and drops the request
  a_r10_enter: assert property (@(posedge clk) disable iff (!rstN)
    (intReq && intAck) |=> (!intReq && curLevel == $past(intClass)));
endmodule

// File: tb/nestIrqCtrl_bench.sv
module nestIrqCtrl_bench;
  localparam int N = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] irqIn = '0;
  logic       cfgWe = 1'b0;
  logic [3:0] cfgAddr = '0;
  logic [5:0] cfgWdata = '0;
  logic [5:0] cfgRdata;
  logic       intReq;
  logic [2:0] intVector;
  logic [2:0] intClass;
  logic       intAck = 1'b0;
  logic       levelRestore = 1'b0;
  logic [2:0] curLevel;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  nestIrqCtrl #(.NUM_LINES(N), .CLASS_W(3)) u_nestIrqCtrl (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .intReq(intReq),
    .intVector(intVector), .intClass(intClass), .intAck(intAck),
    .levelRestore(levelRestore), .curLevel(curLevel)
  );

  // classes for the table phase
  localparam logic [2:0] CLS [8] = '{3'd3, 3'd5, 3'd5, 3'd1, 3'd7, 3'd2, 3'd7, 3'd0};
  // {pattern, expect request, expected vector}
  localparam logic [11:0] TABLE [8] = '{
    {8'h01, 1'b1, 3'd0}, {8'h06, 1'b1, 3'd1}, {8'h50, 1'b1, 3'd4},
    {8'h0F, 1'b1, 3'd1}, {8'h80, 1'b0, 3'd0}, {8'h28, 1'b1, 3'd5},
    {8'hFF, 1'b1, 3'd4}, {8'h89, 1'b1, 3'd0}};

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [3:0] a, input logic [5:0] d);
    cfgAddr = a; cfgWdata = d; cfgWe = 1'b1;
    waitN(1);
    cfgWe = 1'b0;
  endtask

  task automatic lineCfg(input int idx, input bit en, input logic [1:0] md, input logic [2:0] cl);
    cfgWrite(4'(idx), {en, md, cl});
  endtask

  task automatic ackPulse();
    intAck = 1'b1; waitN(1); intAck = 1'b0;
  endtask

  task automatic restorePulse();
    levelRestore = 1'b1; waitN(1); levelRestore = 1'b0;
  endtask

  task automatic pulseLine(input int idx);
    irqIn[idx] = 1'b1; waitN(1); irqIn[idx] = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    waitN(3);
    rstN = 1'b1;
    waitN(1);
    // R1 reset state
    chk(intReq == 1'b0, "R1 intReq", intReq, 0);
    chk(curLevel == 3'd0, "R1 curLevel", curLevel, 0);
    cfgAddr = 4'd2; #0.1;
    chk(cfgRdata == 6'd0, "R1 line cfg", cfgRdata, 0);
    cfgAddr = 4'b1000; #0.1;
    chk(cfgRdata == 6'd0, "R1 global", cfgRdata, 0);

    // R2 register map
    lineCfg(3, 1'b1, 2'd1, 3'd6); cfgAddr = 4'd3; #0.1;
    chk(cfgRdata == 6'b101110, "R2 line readback", cfgRdata, 6'b101110);
    cfgWrite(4'b1111, 6'h3F); cfgAddr = 4'b1000; #0.1;
    chk(cfgRdata == 6'h01, "R2 global readback", cfgRdata, 1);

    // R8 arbitration table, all level mode
    for (int i = 0; i < N; i++) lineCfg(i, 1'b1, 2'd0, CLS[i]);
    for (int t = 0; t < 8; t++) begin
      irqIn = TABLE[t][11:4];
      waitN(3);
      chk(intReq == TABLE[t][3], "R8 table request", intReq, TABLE[t][3]);
      if (TABLE[t][3]) begin
        chk(intVector == TABLE[t][2:0], "R8 table vector", intVector, TABLE[t][2:0]);
        ackPulse();
        chk(curLevel == CLS[TABLE[t][2:0]], "R10 level load", curLevel, CLS[TABLE[t][2:0]]);
        irqIn = '0; waitN(2);
        restorePulse();
        chk(curLevel == 3'd0, "R11 level pop", curLevel, 0);
      end else begin
        irqIn = '0; waitN(2);
      end
    end

    // R3 level latency and no memory
    irqIn[0] = 1'b1;
    waitN(1); chk(intReq == 1'b0, "R3 early", intReq, 0);
    waitN(1); chk(intReq == 1'b1 && intVector == 3'd0, "R3 at two edges", intReq, 1);
    ackPulse(); irqIn[0] = 1'b0; waitN(2); restorePulse(); waitN(3);
    chk(intReq == 1'b0, "R3 no memory", intReq, 0);

    // R4 pulse mode
    lineCfg(1, 1'b1, 2'd1, 3'd5);
    pulseLine(1);
    waitN(1); chk(intReq == 1'b0, "R4 early", intReq, 0);
    waitN(1); chk(intReq == 1'b1 && intVector == 3'd1, "R4 sticky request", intVector, 1);
    ackPulse();
    chk(curLevel == 3'd5, "R4 level", curLevel, 5);
    waitN(2); restorePulse(); waitN(3);
    chk(intReq == 1'b0, "R4 cleared by ack", intReq, 0);

    // R5 async mode
    lineCfg(2, 1'b1, 2'd2, 3'd5);
    irqIn[2] = 1'b1;
    waitN(3); chk(intReq == 1'b0, "R5 early", intReq, 0);
    waitN(1); chk(intReq == 1'b1 && intVector == 3'd2, "R5 at four edges", intVector, 2);
    ackPulse(); irqIn[2] = 1'b0; waitN(2); restorePulse(); waitN(3);
    chk(intReq == 1'b0, "R5 cleared by ack", intReq, 0);

    // R9 held request, then nesting
    pulseLine(1); waitN(2);
    chk(intReq && intVector == 3'd1, "R9 first request", intVector, 1);
    irqIn[4] = 1'b1; waitN(3);
    chk(intVector == 3'd1 && intClass == 3'd5, "R9 held vector", intVector, 1);
    ackPulse(); waitN(1);
    chk(intReq && intVector == 3'd4, "R10 preempt", intVector, 4);
    ackPulse();
    chk(curLevel == 3'd7, "R10 nested level", curLevel, 7);
    irqIn[4] = 1'b0; waitN(2);
    restorePulse(); chk(curLevel == 3'd5, "R11 pop to 5", curLevel, 5);
    restorePulse(); chk(curLevel == 3'd0, "R11 pop to 0", curLevel, 0);
    restorePulse(); chk(curLevel == 3'd0, "R11 empty pop", curLevel, 0);

    // R9 stray ack
    ackPulse(); waitN(1);
    chk(curLevel == 3'd0 && !intReq, "R9 ack ignored", curLevel, 0);

    // R11 ack and restore together
    pulseLine(1); waitN(2);
    intAck = 1'b1; levelRestore = 1'b1; waitN(1); intAck = 1'b0; levelRestore = 1'b0;
    chk(curLevel == 3'd5, "R11 restore with ack ignored", curLevel, 5);
    restorePulse(); chk(curLevel == 3'd0, "R11 restore after", curLevel, 0);

    // R6 gating
    cfgWrite(4'b1000, 6'h00); pulseLine(1); waitN(4);
    cfgWrite(4'b1000, 6'h01); waitN(4);
    chk(intReq == 1'b0, "R6 global off edge lost", intReq, 0);
    lineCfg(1, 1'b0, 2'd1, 3'd5); pulseLine(1); waitN(4);
    lineCfg(1, 1'b1, 2'd1, 3'd5); waitN(4);
    chk(intReq == 1'b0, "R6 line off edge lost", intReq, 0);

    // R7 held off at high level, released on restore
    irqIn[4] = 1'b1; waitN(2); ackPulse(); irqIn[4] = 1'b0;
    chk(curLevel == 3'd7, "R7 raise level", curLevel, 7);
    pulseLine(1); waitN(4);
    chk(intReq == 1'b0, "R7 held off", intReq, 0);
    restorePulse(); waitN(2);
    chk(intReq && intVector == 3'd1, "R7 released", intVector, 1);
    ackPulse(); waitN(1); restorePulse();

    // R6 disable discards pending
    irqIn[4] = 1'b1; waitN(2); ackPulse(); irqIn[4] = 1'b0;
    pulseLine(1); waitN(4);
    lineCfg(1, 1'b0, 2'd1, 3'd5); lineCfg(1, 1'b1, 2'd1, 3'd5);
    restorePulse(); waitN(3);
    chk(intReq == 1'b0, "R6 pending discarded", intReq, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule